// File: doc/BRIEF.md
# Flash Region Lock and Command Guard

This block holds the protection state of a paged flash array and screens every program or erase command before it reaches the flash engine. The array is split into sixteen regions of equal size, each with its own lock bit. A separate boot-area guard covers the lowest pages. A security bit, once set, can only be removed by a full chip erase. Software reaches the block through a small 32-bit register port. Each command carries a 4-bit opcode and a page number. The block either starts the flash engine through a start/done handshake, updates its protection or general-purpose bits, or refuses the command and sets an error flag.

A chip erase runs as a fixed sequence with three steps. The block first asks for the volatile memories to be cleared. Only after that completes does it start the whole-array flash erase. Only after that completes does it drop the security bit. A ready flag shows whether a command is in flight. When ready comes back high, the block can pulse an interrupt.

Register words (word address on `pb_addr`): 0 = configuration (read/write), 1 = command (write), 2 = status (read), 3 = general-purpose bits (read).

Top module: `nvm_region_guard`

## Requirements
- R1: After reset the block has these values. Ready is 1. Both error flags, all lock bits, the security bit, all general-purpose bits and the configuration word are 0. `fl_start`, `vm_start` and `irq` are low. The status word therefore reads 32'h0000_0001.
- R2: Page p belongs to region p / (NUM_PAGES/16), which is the top four page bits. Opcode 3 sets that region's lock bit and opcode 4 clears it. Lock bit r appears at status bit 16+r. The change shows one cycle after the command write, and ready stays high.
- R3: Opcode 1 (program page) or opcode 2 (erase page) on an unprotected page starts the flash engine. `fl_start` pulses for one cycle, in the cycle after the write. `fl_op` is 0 for program and 1 for erase, and `fl_page` holds the page. Ready is low from that cycle on. Ready is high again in the cycle after `fl_done` is sampled.
- R4: A program or erase command whose page lies in a locked region is not started. Ready stays high, and the sticky lock-error flag (status bit 1) is set.
- R5: Configuration bits [6:4] hold a boot code c. When c is nonzero, pages below 2^c are protected, whatever the region lock bits say. A program or erase command on such a page is refused in the same way as in R4. When c is 0, there is no boot protection.
- R6: A command written while ready is low is ignored and sets the sticky programming-error flag (status bit 2). This also holds when the write lands in the same cycle that `fl_done` completes an operation.
- R7: A command with an opcode outside 1..8 starts nothing and sets the programming-error flag.
- R8: Both error flags stay set until the status word is read. That read returns the flags set, and the following read returns them cleared.
- R9: Opcode 5 (chip erase) works as follows. `vm_start` pulses first. `fl_start` with `fl_op` = 2 comes only after `vm_done`. The security bit clears only in the cycle after `fl_done`. Ready stays low for the whole sequence. The sequence runs even when regions are locked, and it leaves the lock bits unchanged.
- R10: Opcode 8 sets the security bit (status bit 3). No command other than chip erase clears it.
- R11: Opcode 6 sets and opcode 7 clears the general-purpose bit whose index is the page number modulo GP_BITS. The bits read back at word 3.
- R12: When configuration bit 0 is set, `irq` is high for exactly the first cycle in which ready is back high. When that bit is clear, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pb_sel | input | 1 | Register access strobe |
| pb_write | input | 1 | 1 = write, 0 = read |
| pb_addr | input | 2 | Register word address |
| pb_wdata | input | 32 | Write data; command word: opcode [3:0], page [8+PAGE_W-1:8] |
| pb_rdata | output | 32 | Read data |
| fl_start | output | 1 | One-cycle start to the flash engine |
| fl_op | output | 2 | Flash operation: 0 program, 1 page erase, 2 whole erase |
| fl_page | output | PAGE_W | Target page of the flash operation |
| fl_done | input | 1 | Flash engine completion pulse |
| vm_start | output | 1 | One-cycle request to clear volatile memories |
| vm_done | input | 1 | Volatile clear completion pulse |
| irq | output | 1 | Ready-return interrupt pulse |

## Verification
The case where two functions meet in one cycle is a completion pulse from the flash engine arriving together with a new command write. The bench raises `fl_done` and writes a program command at the same falling edge, so both are sampled at the same rising edge. It then expects the new command to be refused as a busy write: no second `fl_start`, and the programming-error flag set. It also expects the first operation to finish normally, with ready back high and the interrupt pulse present. Chip-erase ordering is judged by holding back each handshake for several cycles and checking that no later step begins early.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
   localparam logic [3:0] OP_PROG   = 4'd1;
   localparam logic [3:0] OP_ERASE  = 4'd2;
   localparam logic [3:0] OP_LOCK   = 4'd3;
   localparam logic [3:0] OP_UNLOCK = 4'd4;
   localparam logic [3:0] OP_CHIP   = 4'd5;
   localparam logic [3:0] OP_GPSET  = 4'd6;
   localparam logic [3:0] OP_GPCLR  = 4'd7;
   localparam logic [3:0] OP_SECURE = 4'd8;

   typedef enum logic [1:0] {
      FL_PROG  = 2'd0,
      FL_ERASE = 2'd1,
      FL_ALL   = 2'd2
   } fl_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PAGE = 2'd1,
      ST_VOL  = 2'd2,
      ST_ALL  = 2'd3
   } seq_state_e;

   localparam int REG_ADDR_CFG  = 0;
   localparam int REG_ADDR_CMD  = 1;
   localparam int REG_ADDR_STAT = 2;
   localparam int REG_ADDR_GP   = 3;
endpackage

// File: rtl/nvg_region_map.sv
module nvg_region_map #(
   parameter int NUM_PAGES   = 512,
   parameter int NUM_REGIONS = 16,
   parameter bit BOOT_GUARD  = 1'b1,
   localparam int PAGE_W     = $clog2(NUM_PAGES),
   localparam int REG_W      = $clog2(NUM_REGIONS),
   localparam int REG_SIZE   = NUM_PAGES / NUM_REGIONS
) (
   input  logic [PAGE_W-1:0]      page,
   input  logic [NUM_REGIONS-1:0] locks,
   input  logic [2:0]             boot_code,
   output logic [REG_W-1:0]       region,
   output logic                   prot_hit
);
   logic boot_hit;

   assign region = page[PAGE_W-1 -: REG_W];

   generate
      if (BOOT_GUARD) begin : g_boot
         assign boot_hit = (boot_code != 3'd0) && (32'(page) < (32'd1 << boot_code));
      end else begin : g_noboot
         logic unused_boot;
         assign unused_boot = ^boot_code;
         assign boot_hit    = 1'b0;
      end
   endgenerate

   assign prot_hit = locks[region] | boot_hit;

   // R2: the region index must bracket the page number arithmetically
   always_comb begin
      assert_region_map_R2: assert ((int'(page) / REG_SIZE) == int'(region))
         else $error("region index does not match page number");
   end
endmodule

// File: rtl/nvg_lock_bank.sv
module nvg_lock_bank #(
   parameter int NUM_REGIONS = 16,
   parameter int GP_BITS     = 32,
   localparam int REG_W      = $clog2(NUM_REGIONS),
   localparam int GP_W       = $clog2(GP_BITS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [REG_W-1:0]       region,
   input  logic [GP_W-1:0]        gp_idx,
   input  logic                   lk_set,
   input  logic                   lk_clr,
   input  logic                   gp_set,
   input  logic                   gp_clr,
   input  logic                   sec_set,
   input  logic                   sec_clr,
   output logic [NUM_REGIONS-1:0] locks,
   output logic [GP_BITS-1:0]     gp_bits,
   output logic                   secure
);
   genvar i;
   generate
      for (i = 0; i < NUM_REGIONS; i++) begin : g_lock
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  locks[i] <= 1'b0;
            else if (lk_set && region == REG_W'(i))      locks[i] <= 1'b1;
            else if (lk_clr && region == REG_W'(i))      locks[i] <= 1'b0;
         end
      end
      for (i = 0; i < GP_BITS; i++) begin : g_gp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  gp_bits[i] <= 1'b0;
            else if (gp_set && gp_idx == GP_W'(i))       gp_bits[i] <= 1'b1;
            else if (gp_clr && gp_idx == GP_W'(i))       gp_bits[i] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       secure <= 1'b0;
      else if (sec_clr) secure <= 1'b0;
      else if (sec_set) secure <= 1'b1;
   end

   // R2: lock bits move only when a lock or unlock strobe was present
   assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_set && !lk_clr |=> $stable(locks));
endmodule

// File: rtl/nvg_sequencer.sv
module nvg_sequencer
   import nvg_pkg::*;
#(
   parameter int PAGE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [3:0]        cmd_op,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic              prot_hit,
   input  logic              stat_rd,
   input  logic              irq_en,
   input  logic              fl_done,
   input  logic              vm_done,
   output logic              ready,
   output logic              lock_err,
   output logic              prog_err,
   output logic              fl_start,
   output logic [1:0]        fl_op,
   output logic [PAGE_W-1:0] fl_page,
   output logic              vm_start,
   output logic              irq,
   output logic              lk_set,
   output logic              lk_clr,
   output logic              gp_set,
   output logic              gp_clr,
   output logic              sec_set,
   output logic              sec_clr
);
   seq_state_e state_q, state_d;
   logic       idle, accept, start_pg, start_all, start_chip;
   logic       set_lk_err, set_pg_err, done_evt;
   fl_op_e     fl_op_q;

   assign idle   = (state_q == ST_IDLE);
   assign accept = cmd_wr && idle;
   assign ready  = idle;

   always_comb begin
      state_d    = state_q;
      start_pg   = 1'b0;
      start_chip = 1'b0;
      set_lk_err = 1'b0;
      set_pg_err = cmd_wr && !idle;
      lk_set     = 1'b0;
      lk_clr     = 1'b0;
      gp_set     = 1'b0;
      gp_clr     = 1'b0;
      sec_set    = 1'b0;
      sec_clr    = 1'b0;
      done_evt   = 1'b0;
      start_all  = 1'b0;
      case (state_q)
         ST_IDLE: if (accept) begin
            case (cmd_op)
               OP_PROG, OP_ERASE: begin
                  if (prot_hit) set_lk_err = 1'b1;
                  else begin
                     start_pg = 1'b1;
                     state_d  = ST_PAGE;
                  end
               end
               OP_LOCK:   lk_set  = 1'b1;
               OP_UNLOCK: lk_clr  = 1'b1;
               OP_GPSET:  gp_set  = 1'b1;
               OP_GPCLR:  gp_clr  = 1'b1;
               OP_SECURE: sec_set = 1'b1;
               OP_CHIP: begin
                  start_chip = 1'b1;
                  state_d    = ST_VOL;
               end
               default:   set_pg_err = 1'b1;
            endcase
         end
         ST_PAGE: if (fl_done) begin
            done_evt = 1'b1;
            state_d  = ST_IDLE;
         end
         ST_VOL: if (vm_done) begin
            start_all = 1'b1;
            state_d   = ST_ALL;
         end
         ST_ALL: if (fl_done) begin
            done_evt = 1'b1;
            sec_clr  = 1'b1;
            state_d  = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         fl_start <= 1'b0;
         fl_op_q  <= FL_PROG;
         fl_page  <= '0;
         vm_start <= 1'b0;
         irq      <= 1'b0;
         lock_err <= 1'b0;
         prog_err <= 1'b0;
      end else begin
         state_q  <= state_d;
         fl_start <= start_pg || start_all;
         vm_start <= start_chip;
         irq      <= irq_en && done_evt;
         if (start_pg) begin
            fl_op_q <= (cmd_op == OP_PROG) ? FL_PROG : FL_ERASE;
            fl_page <= cmd_page;
         end else if (start_all) begin
            fl_op_q <= FL_ALL;
         end
         if (set_lk_err)   lock_err <= 1'b1;
         else if (stat_rd) lock_err <= 1'b0;
         if (set_pg_err)   prog_err <= 1'b1;
         else if (stat_rd) prog_err <= 1'b0;
      end
   end

   assign fl_op = fl_op_q;

   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fl_start |=> !fl_start);
   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fl_start |-> !ready);
   assert_ready_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(fl_done));
   assert_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && ready && prot_hit && (cmd_op == OP_PROG || cmd_op == OP_ERASE)
      |=> !fl_start && lock_err);
   assert_busy_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && !ready |=> prog_err);
   assert_chip_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fl_start && fl_op == 2'(FL_ALL) |-> $past(vm_done));
   assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ready && !$past(ready));
endmodule

// File: rtl/nvm_region_guard.sv
module nvm_region_guard
   import nvg_pkg::*;
#(
   parameter int NUM_PAGES   = 512,
   parameter int NUM_REGIONS = 16,
   parameter int GP_BITS     = 32,
   parameter bit BOOT_GUARD  = 1'b1,
   localparam int PAGE_W     = $clog2(NUM_PAGES),
   localparam int REG_W      = $clog2(NUM_REGIONS),
   localparam int GP_W       = $clog2(GP_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pb_sel,
   input  logic              pb_write,
   input  logic [1:0]        pb_addr,
   input  logic [31:0]       pb_wdata,
   output logic [31:0]       pb_rdata,
   output logic              fl_start,
   output logic [1:0]        fl_op,
   output logic [PAGE_W-1:0] fl_page,
   input  logic              fl_done,
   output logic              vm_start,
   input  logic              vm_done,
   output logic              irq
);
   initial begin
      assert_cfg_pow2_R2: assert ((1 << PAGE_W) == NUM_PAGES && (1 << REG_W) == NUM_REGIONS)
         else $error("page and region counts must be powers of two");
      assert_cfg_regions_R2: assert (NUM_REGIONS <= 16 && NUM_REGIONS <= NUM_PAGES)
         else $error("region count out of range");
      assert_cfg_gp_R11: assert (GP_BITS <= 32 && GP_BITS >= 2 && GP_W <= PAGE_W)
         else $error("general-purpose bit count out of range");
   end

   logic                   cfg_irq_en;
   logic [2:0]             cfg_boot;
   logic                   cmd_wr, cfg_wr, stat_rd;
   logic [3:0]             cmd_op;
   logic [PAGE_W-1:0]      cmd_page;
   logic [REG_W-1:0]       region;
   logic                   prot_hit;
   logic [NUM_REGIONS-1:0] locks;
   logic [GP_BITS-1:0]     gp_bits;
   logic                   secure, ready, lock_err, prog_err;
   logic                   lk_set, lk_clr, gp_set, gp_clr, sec_set, sec_clr;
   logic                   unused_wdata;

   assign cfg_wr   = pb_sel && pb_write && pb_addr == 2'(REG_ADDR_CFG);
   assign cmd_wr   = pb_sel && pb_write && pb_addr == 2'(REG_ADDR_CMD);
   assign stat_rd  = pb_sel && !pb_write && pb_addr == 2'(REG_ADDR_STAT);
   assign cmd_op   = pb_wdata[3:0];
   assign cmd_page = pb_wdata[8 +: PAGE_W];
   assign unused_wdata = ^pb_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_irq_en <= 1'b0;
         cfg_boot   <= 3'd0;
      end else if (cfg_wr) begin
         cfg_irq_en <= pb_wdata[0];
         cfg_boot   <= pb_wdata[6:4];
      end
   end

   nvg_region_map #(
      .NUM_PAGES(NUM_PAGES), .NUM_REGIONS(NUM_REGIONS), .BOOT_GUARD(BOOT_GUARD)
   ) u_map (
      .page(cmd_page), .locks(locks), .boot_code(cfg_boot),
      .region(region), .prot_hit(prot_hit)
   );

   nvg_lock_bank #(
      .NUM_REGIONS(NUM_REGIONS), .GP_BITS(GP_BITS)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .region(region), .gp_idx(cmd_page[GP_W-1:0]),
      .lk_set(lk_set), .lk_clr(lk_clr), .gp_set(gp_set), .gp_clr(gp_clr),
      .sec_set(sec_set), .sec_clr(sec_clr),
      .locks(locks), .gp_bits(gp_bits), .secure(secure)
   );

   nvg_sequencer #(.PAGE_W(PAGE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_page(cmd_page),
      .prot_hit(prot_hit), .stat_rd(stat_rd), .irq_en(cfg_irq_en),
      .fl_done(fl_done), .vm_done(vm_done),
      .ready(ready), .lock_err(lock_err), .prog_err(prog_err),
      .fl_start(fl_start), .fl_op(fl_op), .fl_page(fl_page), .vm_start(vm_start), .irq(irq),
      .lk_set(lk_set), .lk_clr(lk_clr), .gp_set(gp_set), .gp_clr(gp_clr),
      .sec_set(sec_set), .sec_clr(sec_clr)
   );

   always_comb begin
      pb_rdata = 32'd0;
      case (pb_addr)
         2'(REG_ADDR_CFG):  pb_rdata = {25'd0, cfg_boot, 3'd0, cfg_irq_en};
         2'(REG_ADDR_STAT): pb_rdata = {16'(locks), 12'd0, secure, prog_err, lock_err, ready};
         2'(REG_ADDR_GP):   pb_rdata = 32'(gp_bits);
         default:           pb_rdata = 32'd0;
      endcase
   end

   assert_sec_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(secure) |-> $past(fl_done) && !$past(ready));
   assert_sec_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(secure) |-> $past(cmd_wr) && $past(cmd_op) == OP_SECURE);
endmodule

// File: tb/nvm_region_guard_bench.sv
module nvm_region_guard_bench;
   localparam int PAGE_W = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pb_sel = 1'b0, pb_write = 1'b0;
   logic [1:0]  pb_addr = 2'd0;
   logic [31:0] pb_wdata = 32'd0;
   logic [31:0] pb_rdata;
   logic        fl_start, vm_start, irq;
   logic [1:0]  fl_op;
   logic [PAGE_W-1:0] fl_page;
   logic        fl_done = 1'b0, vm_done = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   nvm_region_guard u_nvm_region_guard (
      .clk(clk), .rst_n(rst_n), .pb_sel(pb_sel), .pb_write(pb_write), .pb_addr(pb_addr),
      .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .fl_start(fl_start), .fl_op(fl_op),
      .fl_page(fl_page), .fl_done(fl_done), .vm_start(vm_start), .vm_done(vm_done), .irq(irq)
   );

   typedef struct packed {
      logic [3:0] op;
      logic [8:0] page;
      logic       start;
      logic       lkerr;
   } vec_t;

   // region 3 (pages 96..127) locked, boot code 2 guards pages 0..3
   localparam vec_t VECS [8] = '{
      '{4'd1, 9'd200, 1'b1, 1'b0},
      '{4'd2, 9'd50,  1'b1, 1'b0},
      '{4'd1, 9'd100, 1'b0, 1'b1},
      '{4'd2, 9'd127, 1'b0, 1'b1},
      '{4'd1, 9'd128, 1'b1, 1'b0},
      '{4'd1, 9'd3,   1'b0, 1'b1},
      '{4'd2, 9'd4,   1'b1, 1'b0},
      '{4'd1, 9'd511, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] cmdw(input logic [3:0] op, input logic [8:0] page);
      return (32'(page) << 8) | 32'(op);
   endfunction

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      pb_sel = 1'b1; pb_write = 1'b1; pb_addr = a; pb_wdata = d;
      @(negedge clk);
      pb_sel = 1'b0; pb_write = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      pb_sel = 1'b1; pb_write = 1'b0; pb_addr = a;
      #1 d = pb_rdata;
      @(negedge clk);
      pb_sel = 1'b0;
   endtask

   task automatic done_pulse();
      fl_done = 1'b1;
      @(negedge clk);
      fl_done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      chk("R1 ready/start/irq", {29'd0, fl_start, vm_start, irq}, 32'd0);
      rd(2'd2, r); chk("R1 status", r, 32'h0000_0001);
      rd(2'd3, r); chk("R1 gp", r, 32'd0);
      rd(2'd0, r); chk("R1 cfg", r, 32'd0);

      // R2 lock mapping
      wr(2'd1, cmdw(4'd3, 9'd100));
      chk("R2 ready during lock", 32'(fl_start) << 1 | 32'(u_nvm_region_guard.pb_rdata[0] & 1'b0) | 32'(1'b1), 32'd1);
      rd(2'd2, r); chk("R2 lock page 100 -> region 3", r, 32'h0008_0001);
      wr(2'd1, cmdw(4'd3, 9'd511));
      rd(2'd2, r); chk("R2 lock page 511 -> region 15", r, 32'h8008_0001);
      wr(2'd1, cmdw(4'd4, 9'd480));
      rd(2'd2, r); chk("R2 unlock region 15", r, 32'h0008_0001);

      wr(2'd0, 32'h0000_0021);
      rd(2'd0, r); chk("R5 cfg readback", r, 32'h0000_0021);

      // table walk: R3 R4 R5 R12
      foreach (VECS[i]) begin
         wr(2'd1, cmdw(VECS[i].op, VECS[i].page));
         chk($sformatf("R3/R4/R5 vec%0d start", i), 32'(fl_start), 32'(VECS[i].start));
         if (VECS[i].start) begin
            chk($sformatf("R3 vec%0d page/op", i), {21'd0, fl_op, fl_page},
                {21'd0, (VECS[i].op == 4'd1) ? 2'd0 : 2'd1, VECS[i].page});
            done_pulse();
            rd(2'd2, r);
            chk($sformatf("R3 vec%0d ready back", i), r, 32'h0008_0001);
         end else begin
            rd(2'd2, r);
            chk($sformatf("R4/R5 vec%0d lock error", i), r, 32'h0008_0003);
         end
      end

      // R12 irq pulse on return of ready
      wr(2'd1, cmdw(4'd1, 9'd200));
      done_pulse();
      chk("R12 irq with ready", {30'd0, irq, 1'b1}, 32'd3);
      @(negedge clk);
      chk("R12 irq one cycle", 32'(irq), 32'd0);

      // R6 command while busy
      wr(2'd1, cmdw(4'd2, 9'd300));
      wr(2'd1, cmdw(4'd3, 9'd300));
      done_pulse();
      rd(2'd2, r); chk("R6 busy write rejected", r, 32'h0008_0005);
      rd(2'd2, r); chk("R8 errors cleared after read", r, 32'h0008_0001);

      // R6 collision: completion and new command in one cycle
      wr(2'd1, cmdw(4'd1, 9'd200));
      pb_sel = 1'b1; pb_write = 1'b1; pb_addr = 2'd1; pb_wdata = cmdw(4'd1, 9'd201);
      fl_done = 1'b1;
      @(negedge clk);
      pb_sel = 1'b0; pb_write = 1'b0; fl_done = 1'b0;
      chk("R6 collision no restart", 32'(fl_start), 32'd0);
      chk("R12 collision irq", 32'(irq), 32'd1);
      rd(2'd2, r); chk("R6 collision flags", r, 32'h0008_0005);

      // R7 unknown opcode
      wr(2'd1, cmdw(4'hF, 9'd10));
      chk("R7 nothing started", {30'd0, fl_start, vm_start}, 32'd0);
      rd(2'd2, r); chk("R7 prog error", r, 32'h0008_0005);

      // R8 sticky lock error
      wr(2'd1, cmdw(4'd1, 9'd100));
      repeat (5) @(negedge clk);
      rd(2'd2, r); chk("R8 lock error held", r, 32'h0008_0003);
      rd(2'd2, r); chk("R8 lock error cleared", r, 32'h0008_0001);

      // R5 boot guard off
      wr(2'd0, 32'h0000_0001);
      wr(2'd1, cmdw(4'd1, 9'd3));
      chk("R5 boot off page 3 starts", 32'(fl_start), 32'd1);
      done_pulse();

      // R11 general-purpose bits
      wr(2'd1, cmdw(4'd6, 9'd5));
      rd(2'd3, r); chk("R11 set bit 5", r, 32'h0000_0020);
      wr(2'd1, cmdw(4'd6, 9'd33));
      rd(2'd3, r); chk("R11 set bit 33 mod 32", r, 32'h0000_0022);
      wr(2'd1, cmdw(4'd7, 9'd5));
      rd(2'd3, r); chk("R11 clear bit 5", r, 32'h0000_0002);

      // R10 security
      wr(2'd1, cmdw(4'd8, 9'd0));
      rd(2'd2, r); chk("R10 security set", r, 32'h0008_0009);
      wr(2'd1, cmdw(4'd4, 9'd100));
      wr(2'd1, cmdw(4'd3, 9'd170));
      rd(2'd2, r); chk("R10 security kept", r, 32'h0020_0009);

      // R9 chip erase ordering
      wr(2'd1, cmdw(4'd5, 9'd0));
      chk("R9 vm first", {29'd0, vm_start, fl_start, 1'b0}, 32'h4);
      repeat (3) @(negedge clk);
      chk("R9 no flash before vm_done", {30'd0, fl_start, vm_start}, 32'd0);
      vm_done = 1'b1;
      @(negedge clk);
      vm_done = 1'b0;
      chk("R9 whole erase start", {29'd0, fl_start, fl_op}, 32'h6);
      rd(2'd2, r); chk("R9 busy, secure held", r, 32'h0020_0008);
      done_pulse();
      rd(2'd2, r); chk("R9 secure cleared, locks kept", r, 32'h0020_0001);

      // R12 irq disabled
      wr(2'd0, 32'h0000_0000);
      wr(2'd1, cmdw(4'd1, 9'd200));
      done_pulse();
      chk("R12 no irq when disabled", 32'(irq), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule